// File: doc/BRIEF.md
# DMA Semaphore Command Unit

This block holds a bank of counting semaphores. A DMA request queue uses them to line up its transfers with the compute side. Each request can carry a 32-bit semaphore command word. The command either changes a semaphore, or blocks the request until a semaphore reaches a condition. It can also hold the request until the DMA transfers in one or both directions have drained. The unit answers on the same cycle: either done or stall. A stalled requester keeps the same command word presented. The unit re-evaluates that command on every cycle until it can complete.

The compute side has a second write path into the bank. It can set, increment or decrement any semaphore. It can also read any semaphore through a combinational read port. The request path decides when a command word is presented, before its transfer or after it. The unit treats both cases the same way. The outstanding-transfer counts in each direction are inputs, supplied by the transfer engines.

Top module: `sem_cmd_unit`

## Requirements
- R1: When bit 31 of the command word is 0, a presented command completes in the cycle it is presented, with no error and no change to any semaphore. This holds whatever its opcode and fence bits are.
- R2: Bits 26:24 hold the opcode, bits 20:16 the semaphore index and bits 11:0 the 12-bit operand. Opcode 1 loads the operand into the indexed semaphore at the clock edge that completes it.
- R3: Opcode 2 adds one and saturates at 0xFFF. Opcode 3 subtracts one and saturates at 0.
- R4: Opcode 4 stalls while the semaphore differs from the operand. The condition is re-checked every cycle, and the command completes in the first cycle of equality without changing the semaphore.
- R5: Opcode 5 stalls while the semaphore is below the operand, and completes when it is greater than or equal to the operand, with no change.
- R6: Opcode 6 stalls while the semaphore is 0. Otherwise it completes and decrements by one in the same cycle. An external update to the same semaphore in that cycle is applied on top of the decremented value.
- R7: With bit 31 set, bit 30 stalls the command while the to-device outstanding count is non-zero. Bit 29 does the same for the from-device count. A count whose fence bit is clear has no effect.
- R8: Opcode 7 completes with the error output high and leaves every semaphore unchanged.
- R9: Opcode 0 completes with no change. Bits 28:27, 23, 22, 21 and 15:12 do not affect the result of any command.
- R10: The external port applies operation 0 (set to value), 1 (increment, saturating at 0xFFF), 2 (decrement, saturating at 0) or 3 (no change) at the clock edge. It acts after any request update to the same semaphore in that cycle.
- R11: During and after reset, every semaphore reads 0. Done and stall are low whenever no command is presented.
- R12: While a command is presented, exactly one of done and stall is high. The error output is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A command word is presented |
| req_cmd | input | 32 | Semaphore command word |
| req_done | output | 1 | Command completes at this clock edge |
| req_stall | output | 1 | Command cannot complete; hold it presented |
| req_err | output | 1 | Completed command had a reserved opcode |
| tod_pending | input | CNT_W | Outstanding to-device transfers |
| fromd_pending | input | CNT_W | Outstanding from-device transfers |
| ext_valid | input | 1 | External update strobe |
| ext_op | input | 2 | External operation: 0 set, 1 inc, 2 dec, 3 none |
| ext_idx | input | 5 | Semaphore index for the external update |
| ext_val | input | 12 | Value for the external set |
| rd_idx | input | 5 | Semaphore index for the read port |
| rd_val | output | 12 | Current value of the addressed semaphore |

## Verification
The bench builds the unit with the full bank of 32 semaphores and with the outstanding-count width narrowed to 4 bits. At that size a sweep can load and read back every semaphore index. The same bench reaches both saturation limits and holds fences with small counts. Waits and the take operation are kept stalled across several cycles while the external port moves the semaphore. This exposes the cycle on which each condition first becomes true, and the ordering when request and external updates hit the same semaphore on the same edge.

// File: rtl/sem_cmd_pkg.sv
// Package: shared field positions, opcode encodings, command struct and
// saturating arithmetic for the semaphore command unit.
package sem_cmd_pkg;

    localparam int SEM_VAL_W = 12;
    localparam int SEM_IDX_W = 5;
    localparam logic [SEM_VAL_W-1:0] SEM_MAX = '1;

    localparam int F_EN       = 31;
    localparam int F_FENCE_TD = 30;
    localparam int F_FENCE_FD = 29;
    localparam int F_OP_LO    = 24;
    localparam int F_IDX_LO   = 16;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_INIT    = 3'd1,
        OP_INC     = 3'd2,
        OP_DEC     = 3'd3,
        OP_WAIT_EQ = 3'd4,
        OP_WAIT_GE = 3'd5,
        OP_TAKE    = 3'd6,
        OP_RSVD    = 3'd7
    } sem_op_e;

    typedef enum logic [1:0] {
        EXT_SET  = 2'd0,
        EXT_INC  = 2'd1,
        EXT_DEC  = 2'd2,
        EXT_HOLD = 2'd3
    } ext_op_e;

    typedef struct packed {
        logic                 en;
        logic                 fence_td;
        logic                 fence_fd;
        sem_op_e              op;
        logic [SEM_IDX_W-1:0] idx;
        logic [SEM_VAL_W-1:0] val;
    } sem_cmd_t;

    function automatic logic [SEM_VAL_W-1:0] sat_inc(input logic [SEM_VAL_W-1:0] v);
        return (v == SEM_MAX) ? v : v + 1'b1;
    endfunction

    function automatic logic [SEM_VAL_W-1:0] sat_dec(input logic [SEM_VAL_W-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

endpackage

// File: rtl/sem_cmd_decode.sv
// Module: sem_cmd_decode
// Splits the 32-bit command word into its fields. Purely combinational.
// Assumes the word is stable while presented; reserved bits are dropped.
module sem_cmd_decode
    import sem_cmd_pkg::*;
(
    input  logic [31:0] cmd_word,
    output sem_cmd_t    cmd
);

    logic unused_rsvd;

    // Field extraction
    always_comb begin
        cmd.en       = cmd_word[F_EN];
        cmd.fence_td = cmd_word[F_FENCE_TD];
        cmd.fence_fd = cmd_word[F_FENCE_FD];
        cmd.op       = sem_op_e'(cmd_word[F_OP_LO +: 3]);
        cmd.idx      = cmd_word[F_IDX_LO +: SEM_IDX_W];
        cmd.val      = cmd_word[SEM_VAL_W-1:0];
    end

    // Reserved bits and the pre/post-sync flag do not change behaviour
    assign unused_rsvd = ^{cmd_word[28:27], cmd_word[23:21], cmd_word[15:12]};

endmodule

// File: rtl/sem_cond_eval.sv
// Module: sem_cond_eval
// Decides whether a decoded command can complete this cycle, whether it
// writes its semaphore, the value written, and whether it is an error.
// Assumes cur_val is the registered value of the indexed semaphore.
module sem_cond_eval
    import sem_cmd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  sem_cmd_t             cmd,
    input  logic [SEM_VAL_W-1:0] cur_val,
    input  logic [CNT_W-1:0]     tod_pending,
    input  logic [CNT_W-1:0]     fromd_pending,
    output logic                 ready,
    output logic                 wr,
    output logic [SEM_VAL_W-1:0] nxt_val,
    output logic                 err
);

    logic fence_ok;

    // Fences: each selected direction must have no transfer outstanding
    always_comb begin
        fence_ok = 1'b1;
        if (cmd.fence_td && (tod_pending != '0))   fence_ok = 1'b0;
        if (cmd.fence_fd && (fromd_pending != '0)) fence_ok = 1'b0;
    end

    // Opcode condition and update value
    always_comb begin
        ready   = fence_ok;
        wr      = 1'b0;
        nxt_val = cur_val;
        err     = 1'b0;
        if (!cmd.en) begin
            ready = 1'b1;
        end else begin
            unique case (cmd.op)
                OP_NOP:     ;
                OP_INIT:    begin wr = 1'b1; nxt_val = cmd.val; end
                OP_INC:     begin wr = 1'b1; nxt_val = sat_inc(cur_val); end
                OP_DEC:     begin wr = 1'b1; nxt_val = sat_dec(cur_val); end
                OP_WAIT_EQ: ready = fence_ok && (cur_val == cmd.val);
                OP_WAIT_GE: ready = fence_ok && (cur_val >= cmd.val);
                OP_TAKE: begin
                    ready   = fence_ok && (cur_val != '0);
                    wr      = 1'b1;
                    nxt_val = cur_val - 1'b1;
                end
                OP_RSVD:    err = 1'b1;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/sem_bank.sv
// Module: sem_bank
// Storage for NUM_SEM 12-bit semaphores. A request update and an external
// update may land on the same edge; the external one applies to the result
// of the request one. Indices at or above NUM_SEM read 0 and are not written.
module sem_bank
    import sem_cmd_pkg::*;
#(
    parameter int NUM_SEM = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_we,
    input  logic [SEM_IDX_W-1:0] req_idx,
    input  logic [SEM_VAL_W-1:0] req_nxt,
    output logic [SEM_VAL_W-1:0] req_cur,
    input  logic                 ext_valid,
    input  logic [1:0]           ext_op,
    input  logic [SEM_IDX_W-1:0] ext_idx,
    input  logic [SEM_VAL_W-1:0] ext_val,
    input  logic [SEM_IDX_W-1:0] rd_idx,
    output logic [SEM_VAL_W-1:0] rd_val
);

    logic [NUM_SEM-1:0][SEM_VAL_W-1:0] sem_vec;

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_slot
        logic [SEM_VAL_W-1:0] slot_q;
        logic [SEM_VAL_W-1:0] after_req;
        logic [SEM_VAL_W-1:0] after_ext;

        // Request update first, then external update on top of it
        always_comb begin
            after_req = (req_we && (req_idx == SEM_IDX_W'(g))) ? req_nxt : slot_q;
            after_ext = after_req;
            if (ext_valid && (ext_idx == SEM_IDX_W'(g))) begin
                unique case (ext_op_e'(ext_op))
                    EXT_SET:  after_ext = ext_val;
                    EXT_INC:  after_ext = sat_inc(after_req);
                    EXT_DEC:  after_ext = sat_dec(after_req);
                    EXT_HOLD: after_ext = after_req;
                    default:  after_ext = after_req;
                endcase
            end
        end

        // Slot register with synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= after_ext;
        end

        assign sem_vec[g] = slot_q;
    end

    // Read muxes for the request path and the external read port
    always_comb begin
        req_cur = '0;
        rd_val  = '0;
        for (int i = 0; i < NUM_SEM; i++) begin
            if (req_idx == SEM_IDX_W'(i)) req_cur = sem_vec[i];
            if (rd_idx  == SEM_IDX_W'(i)) rd_val  = sem_vec[i];
        end
    end

endmodule

// File: rtl/sem_cmd_unit.sv
// Module: sem_cmd_unit (top)
// Semaphore command unit: decodes a request's command word, checks its
// condition and fences against the bank, and answers done or stall in the
// same cycle. Assumes the requester holds req_cmd stable while stalled.
module sem_cmd_unit
    import sem_cmd_pkg::*;
#(
    parameter int NUM_SEM = 32,
    parameter int CNT_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [31:0]          req_cmd,
    output logic                 req_done,
    output logic                 req_stall,
    output logic                 req_err,
    input  logic [CNT_W-1:0]     tod_pending,
    input  logic [CNT_W-1:0]     fromd_pending,
    input  logic                 ext_valid,
    input  logic [1:0]           ext_op,
    input  logic [SEM_IDX_W-1:0] ext_idx,
    input  logic [SEM_VAL_W-1:0] ext_val,
    input  logic [SEM_IDX_W-1:0] rd_idx,
    output logic [SEM_VAL_W-1:0] rd_val
);

    sem_cmd_t             cmd;
    logic [SEM_VAL_W-1:0] cur_val;
    logic [SEM_VAL_W-1:0] nxt_val;
    logic                 ready;
    logic                 wr;
    logic                 eval_err;

    sem_cmd_decode u_dec (
        .cmd_word (req_cmd),
        .cmd      (cmd)
    );

    sem_cond_eval #(.CNT_W(CNT_W)) u_eval (
        .cmd           (cmd),
        .cur_val       (cur_val),
        .tod_pending   (tod_pending),
        .fromd_pending (fromd_pending),
        .ready         (ready),
        .wr            (wr),
        .nxt_val       (nxt_val),
        .err           (eval_err)
    );

    sem_bank #(.NUM_SEM(NUM_SEM)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_we    (req_done & wr),
        .req_idx   (cmd.idx),
        .req_nxt   (nxt_val),
        .req_cur   (cur_val),
        .ext_valid (ext_valid),
        .ext_op    (ext_op),
        .ext_idx   (ext_idx),
        .ext_val   (ext_val),
        .rd_idx    (rd_idx),
        .rd_val    (rd_val)
    );

    // Handshake answer
    assign req_done  = req_valid & ready;
    assign req_stall = req_valid & ~ready;
    assign req_err   = req_done & eval_err;

endmodule

// File: rtl/sem_cmd_unit_chk.sv
// Module: sem_cmd_unit_chk
// Property checker bound into sem_cmd_unit. Observes ports and the value
// the bank returns for the indexed semaphore.
module sem_cmd_unit_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [31:0]      req_cmd,
    input logic             req_done,
    input logic             req_stall,
    input logic             req_err,
    input logic [CNT_W-1:0] tod_pending,
    input logic [CNT_W-1:0] fromd_pending,
    input logic [11:0]      cur_val
);

    logic       en;
    logic [2:0] op;
    assign en = req_valid && req_cmd[31];
    assign op = req_cmd[26:24];

    p_one_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_done ^ req_stall));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_done && !req_stall));

    p_err_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_done);

    p_disabled_passes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_cmd[31]) |-> (req_done && !req_err));

    p_err_only_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (en && op == 3'd7));

    p_tod_fence_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && req_cmd[30] && tod_pending != '0) |-> req_stall);

    p_fromd_fence_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && req_cmd[29] && fromd_pending != '0) |-> req_stall);

    p_take_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd6 && cur_val == '0) |-> req_stall);

    p_eq_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd4 && cur_val != req_cmd[11:0]) |-> req_stall);

    p_ge_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 3'd5 && cur_val < req_cmd[11:0]) |-> req_stall);

endmodule

bind sem_cmd_unit sem_cmd_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_cmd       (req_cmd),
    .req_done      (req_done),
    .req_stall     (req_stall),
    .req_err       (req_err),
    .tod_pending   (tod_pending),
    .fromd_pending (fromd_pending),
    .cur_val       (cur_val)
);

// File: tb/sem_cmd_unit_tb.sv
// Bench for sem_cmd_unit: drives at the falling edge, samples 1 time unit
// later, and keeps its own model of every semaphore.
module sem_cmd_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NSEM = 32;
    localparam int CW   = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [31:0]   req_cmd;
    logic          req_done, req_stall, req_err;
    logic [CW-1:0] tod_pending, fromd_pending;
    logic          ext_valid;
    logic [1:0]    ext_op;
    logic [4:0]    ext_idx, rd_idx;
    logic [11:0]   ext_val, rd_val;

    int n_checks = 0;
    int n_fail   = 0;
    logic [11:0] model [NSEM];

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_cmd_unit #(.NUM_SEM(NSEM), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_done(req_done), .req_stall(req_stall), .req_err(req_err),
        .tod_pending(tod_pending), .fromd_pending(fromd_pending),
        .ext_valid(ext_valid), .ext_op(ext_op), .ext_idx(ext_idx),
        .ext_val(ext_val), .rd_idx(rd_idx), .rd_val(rd_val)
    );

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] op, input logic [4:0] idx,
                                       input logic [11:0] val);
        return 32'h8000_0000 | (32'(op) << 24) | (32'(idx) << 16) | 32'(val);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Present a command for one cycle, capturing the same-cycle answer
    task automatic issue(input logic [31:0] c, output logic d, output logic s,
                         output logic e);
        req_valid = 1'b1;
        req_cmd   = c;
        #1;
        d = req_done; s = req_stall; e = req_err;
        tick();
        req_valid = 1'b0;
    endtask

    task automatic rd_chk(input string rq, input logic [4:0] i, input logic [11:0] exp);
        rd_idx = i;
        #1;
        chk(rq, {20'd0, rd_val}, {20'd0, exp});
    endtask

    task automatic ext(input logic [1:0] op, input logic [4:0] i, input logic [11:0] v);
        ext_valid = 1'b1; ext_op = op; ext_idx = i; ext_val = v;
        tick();
        ext_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R12: watchdog expired, actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic d, s, e;
        rst_n = 1'b0; req_valid = 1'b0; req_cmd = '0;
        tod_pending = '0; fromd_pending = '0;
        ext_valid = 1'b0; ext_op = '0; ext_idx = '0; ext_val = '0; rd_idx = '0;
        @(negedge clk);
        repeat (3) tick();
        // R11: outputs quiet and bank cleared under reset
        chk("R11 done idle", {31'd0, req_done}, 0);
        chk("R11 stall idle", {31'd0, req_stall}, 0);
        for (int i = 0; i < NSEM; i++) rd_chk("R11 reset value", 5'(i), 12'd0);
        rst_n = 1'b1;
        tick();
        chk("R11 done idle after reset", {31'd0, req_done}, 0);

        // R2: load every index, then read all back
        for (int i = 0; i < NSEM; i++) begin
            model[i] = 12'((i * 97 + 5) & 12'hFFF);
            issue(mk(3'd1, 5'(i), model[i]), d, s, e);
            chk("R2 init done", {31'd0, d}, 1);
            chk("R12 init no stall", {31'd0, s}, 0);
        end
        for (int i = 0; i < NSEM; i++) rd_chk("R2 init readback", 5'(i), model[i]);

        // R3: saturating increment and decrement
        issue(mk(3'd1, 5'd1, 12'hFFE), d, s, e);
        issue(mk(3'd2, 5'd1, 12'd0), d, s, e);
        rd_chk("R3 inc", 5'd1, 12'hFFF);
        issue(mk(3'd2, 5'd1, 12'd0), d, s, e);
        rd_chk("R3 inc saturates", 5'd1, 12'hFFF);
        issue(mk(3'd1, 5'd2, 12'd1), d, s, e);
        issue(mk(3'd3, 5'd2, 12'd0), d, s, e);
        rd_chk("R3 dec", 5'd2, 12'd0);
        issue(mk(3'd3, 5'd2, 12'd0), d, s, e);
        rd_chk("R3 dec saturates", 5'd2, 12'd0);

        // R9: reserved bits and the pre-sync flag set
        issue(mk(3'd1, 5'd5, 12'h3A5) | 32'h18E0_F000, d, s, e);
        chk("R9 rsvd bits done", {31'd0, d}, 1);
        rd_chk("R9 rsvd bits ignored", 5'd5, 12'h3A5);
        issue(mk(3'd0, 5'd5, 12'h111) | 32'h18E0_F000, d, s, e);
        chk("R9 nop done", {31'd0, d}, 1);
        rd_chk("R9 nop no change", 5'd5, 12'h3A5);

        // R1: disabled command, even with a fence and pending transfers
        tod_pending = 4'd5;
        issue((mk(3'd1, 5'd5, 12'h111) | 32'h4000_0000) & 32'h7FFF_FFFF, d, s, e);
        chk("R1 disabled done", {31'd0, d}, 1);
        chk("R1 disabled no err", {31'd0, e}, 0);
        rd_chk("R1 disabled no change", 5'd5, 12'h3A5);
        tod_pending = '0;

        // R8: reserved opcode
        issue(mk(3'd7, 5'd5, 12'h000), d, s, e);
        chk("R8 rsvd done", {31'd0, d}, 1);
        chk("R8 rsvd err", {31'd0, e}, 1);
        rd_chk("R8 rsvd no change", 5'd5, 12'h3A5);

        // R4: wait-equal held while the external side counts up
        issue(mk(3'd1, 5'd6, 12'd5), d, s, e);
        req_valid = 1'b1; req_cmd = mk(3'd4, 5'd6, 12'd7);
        #1 chk("R4 stall at 5", {31'd0, req_stall}, 1);
        ext(2'd1, 5'd6, 12'd0);
        #1 chk("R4 stall at 6", {31'd0, req_stall}, 1);
        chk("R4 not done at 6", {31'd0, req_done}, 0);
        ext(2'd1, 5'd6, 12'd0);
        #1 chk("R4 done at 7", {31'd0, req_done}, 1);
        tick();
        req_valid = 1'b0;
        rd_chk("R4 wait leaves value", 5'd6, 12'd7);

        // R5: wait-greater-or-equal
        req_valid = 1'b1; req_cmd = mk(3'd5, 5'd6, 12'h800);
        #1 chk("R5 stall below", {31'd0, req_stall}, 1);
        ext(2'd0, 5'd6, 12'h900);
        #1 chk("R5 done above", {31'd0, req_done}, 1);
        tick();
        req_valid = 1'b0;
        issue(mk(3'd5, 5'd6, 12'h900), d, s, e);
        chk("R5 done at equal", {31'd0, d}, 1);
        rd_chk("R5 wait leaves value", 5'd6, 12'h900);

        // R6: take blocks at zero, then races with external updates
        issue(mk(3'd1, 5'd7, 12'd0), d, s, e);
        req_valid = 1'b1; req_cmd = mk(3'd6, 5'd7, 12'd0);
        #1 chk("R6 stall at zero", {31'd0, req_stall}, 1);
        ext(2'd0, 5'd7, 12'd2);
        ext_valid = 1'b1; ext_op = 2'd1; ext_idx = 5'd7;
        #1 chk("R6 done at 2", {31'd0, req_done}, 1);
        tick();
        ext_valid = 1'b0; req_valid = 1'b0;
        rd_chk("R6 take then ext inc", 5'd7, 12'd2);
        issue(mk(3'd6, 5'd7, 12'd0), d, s, e);
        rd_chk("R6 take decrements", 5'd7, 12'd1);
        ext_valid = 1'b1; ext_op = 2'd2; ext_idx = 5'd7;
        issue(mk(3'd6, 5'd7, 12'd0), d, s, e);
        ext_valid = 1'b0;
        chk("R6 take done at 1", {31'd0, d}, 1);
        rd_chk("R6 take then ext dec floor", 5'd7, 12'd0);

        // R10: external port on its own and against a request update
        ext(2'd0, 5'd8, 12'hFFF);
        rd_chk("R10 ext set", 5'd8, 12'hFFF);
        ext(2'd1, 5'd8, 12'd0);
        rd_chk("R10 ext inc saturates", 5'd8, 12'hFFF);
        ext(2'd2, 5'd8, 12'd0);
        rd_chk("R10 ext dec", 5'd8, 12'hFFE);
        ext(2'd3, 5'd8, 12'd0);
        rd_chk("R10 ext hold", 5'd8, 12'hFFE);
        ext(2'd0, 5'd9, 12'd0);
        ext(2'd2, 5'd9, 12'd0);
        rd_chk("R10 ext dec floor", 5'd9, 12'd0);
        ext_valid = 1'b1; ext_op = 2'd0; ext_idx = 5'd9; ext_val = 12'h0AB;
        issue(mk(3'd1, 5'd9, 12'h123), d, s, e);
        ext_valid = 1'b0;
        rd_chk("R10 ext after request", 5'd9, 12'h0AB);

        // R7: to-device and from-device fences
        issue(mk(3'd1, 5'd10, 12'd0), d, s, e);
        tod_pending = 4'd3;
        req_valid = 1'b1; req_cmd = mk(3'd2, 5'd10, 12'd0) | 32'h4000_0000;
        #1 chk("R7 tod fence stall", {31'd0, req_stall}, 1);
        tick();
        #1 chk("R7 tod fence still stall", {31'd0, req_stall}, 1);
        rd_chk("R7 no update while fenced", 5'd10, 12'd0);
        tod_pending = '0;
        #1 chk("R7 tod fence release", {31'd0, req_done}, 1);
        tick();
        req_valid = 1'b0;
        rd_chk("R7 inc after tod fence", 5'd10, 12'd1);
        fromd_pending = 4'd2; tod_pending = 4'd4;
        req_valid = 1'b1; req_cmd = mk(3'd2, 5'd10, 12'd0) | 32'h2000_0000;
        #1 chk("R7 fromd fence stall", {31'd0, req_stall}, 1);
        tick();
        fromd_pending = '0;
        #1 chk("R7 unselected tod ignored", {31'd0, req_done}, 1);
        tick();
        req_valid = 1'b0; tod_pending = '0;
        rd_chk("R7 inc after fromd fence", 5'd10, 12'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule